// File: doc/BRIEF.md
# Three-Wire Radio Register Serial Master

This block is the serial master for the control port of a radio front-end. It owns three lines toward the radio: a frame enable that idles high and goes low for the span of a transaction, a serial clock, and a bidirectional data line. The data line is brought out as a separate output, output enable and input so that the pad ring can build the tristate. A fourth line, a read/write strobe, marks the point where a read turns the data line around.

A host asks for a transaction with a one-cycle `req` pulse. With it, the host gives the direction, the register address and, for a write, the data. The block stays busy until the frame enable is high again. It then pulses `done`. For a read, it presents the returned word on `rd_data` in that same cycle. Every step of a frame lasts one bit period of `CLK_DIV` system clocks, set by a clock-enable divider that restarts on each accepted request.

Top module: `rfreg_3w_master`

## Requirements
- R1: After reset and whenever the block is idle, `rf_en` is 1, `rf_clk` is 0, `rf_dat_oe` is 1, `busy` and `done` are 0. `rf_rw` is 0 after reset.
- R2: A write sends the 16-bit word `{req_wdata[11:0], req_addr[3:0]}` most significant bit first. It sends one bit per `rf_clk` edge, and the first edge is a rising edge. `rf_dat_o` never changes in the cycle in which `rf_clk` changes.
- R3: The cycle after an accepted request, `rf_en` stays high for one more bit period and then falls with `rf_clk` low. It stays low for 33 bit periods on a write and 37 on a read, and it rises again with `rf_clk` low. `rf_clk` changes only while `rf_en` is low.
- R4: On a write, `busy` is high for exactly 34·`CLK_DIV` cycles, starting in the cycle after the accepted request. `done` is a single-cycle pulse in the cycle in which `busy` falls and `rf_en` rises.
- R5: A read sends `req_addr[4:0]` most significant bit first on the first five `rf_clk` edges, while `rf_rw` is 0.
- R6: After the fifth address edge, `rf_rw` rises together with a falling `rf_clk` edge. `rf_dat_oe` falls one bit period later. The first rising `rf_clk` edge of the return phase follows one bit period after that.
- R7: The return phase captures 12 bits most significant bit first. Each bit is taken from `rf_dat_i` at the falling `rf_clk` edge that ends a bit period of high clock. The word appears on `rd_data` in the `done` cycle.
- R8: On a read, `busy` lasts 38·`CLK_DIV` cycles. At the close, `rf_en`, `rf_rw` and `rf_dat_oe` are all 1. `rf_rw` stays 1 until the next frame opens.
- R9: A `req` pulse that arrives while `busy` is 1 has no effect. The running frame keeps its bits and its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Transaction request, one cycle |
| req_rd | input | 1 | 1 selects a read, 0 a write |
| req_addr | input | RD_ADDR_W (5) | Register address; a write uses the low WR_ADDR_W bits |
| req_wdata | input | DATA_W (12) | Write data |
| busy | output | 1 | High from the accepted request until the enable returns high |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | DATA_W (12) | Word returned by the last read |
| rf_en | output | 1 | Frame enable, low during a frame |
| rf_clk | output | 1 | Serial clock |
| rf_dat_o | output | 1 | Serial data driven toward the radio |
| rf_dat_oe | output | 1 | Output enable for the data line |
| rf_dat_i | input | 1 | Serial data from the radio |
| rf_rw | output | 1 | Read/write strobe for the turnaround |

## Verification
The assertions assume that `rf_dat_i` matters only while the block has released the line. They also assume that the request inputs are sampled only in idle cycles. Any value on them during a frame is therefore legal, and the stimulus makes use of this: it changes `req_wdata` mid-frame and also pulses `req` mid-frame with different fields. The stand-in radio changes `rf_dat_i` only at the falling system-clock edge, after it sees a falling serial clock. A captured bit therefore never changes in the cycle in which the block samples it.

// File: rtl/rfreg_3w_pkg.sv
package rfreg_3w_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // enable high, waiting for a request
        ST_LEAD,   // enable held high for one period before opening
        ST_OPEN,   // enable low, clock low, line driven
        ST_SEND,   // outgoing bits, two periods each
        ST_TURN,   // read/write strobe raised, clock fell
        ST_REL,    // data line released to the radio
        ST_RECV    // incoming bits, two periods each
    } step_e;

endpackage

// File: rtl/rfreg_3w_tick.sv
module rfreg_3w_tick #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr || cnt_q == LAST) cnt_d = '0;
        else                      cnt_d = cnt_q + 1'b1;
    end

    assign tick = !clr && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rfreg_3w_fsm.sv
module rfreg_3w_fsm
    import rfreg_3w_pkg::*;
#(
    parameter int WR_ADDR_W = 4,
    parameter int RD_ADDR_W = 5,
    parameter int DATA_W    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 start,
    input  logic                 start_rd,
    input  logic [RD_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic                 sdi,
    output logic                 clr,
    output logic                 busy,
    output logic                 done,
    output logic [DATA_W-1:0]    rdata,
    output logic                 sen,
    output logic                 sclk,
    output logic                 sdo,
    output logic                 soe,
    output logic                 srw
);
    localparam int WFRAME = DATA_W + WR_ADDR_W;
    localparam int SH_W   = (WFRAME > RD_ADDR_W) ? WFRAME : RD_ADDR_W;
    localparam int IW     = $clog2(SH_W + DATA_W);

    typedef struct packed {
        step_e             st;
        logic              ph;
        logic              rd;
        logic [IW-1:0]     idx;
        logic [SH_W-1:0]   sreg;
        logic [DATA_W-1:0] rsh;
        logic [DATA_W-1:0] rdata;
        logic              sen;
        logic              sclk;
        logic              sdo;
        logic              soe;
        logic              srw;
        logic              busy;
        logic              done;
    } state_t;

    state_t s_d, s_q;

    assign clr = (s_q.st == ST_IDLE) && start;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st   = ST_LEAD;
                    s_d.busy = 1'b1;
                    s_d.rd   = start_rd;
                    s_d.rsh  = '0;
                    if (start_rd) begin
                        s_d.sreg = SH_W'(addr) << (SH_W - RD_ADDR_W);
                        s_d.idx  = IW'(RD_ADDR_W - 1);
                    end else begin
                        s_d.sreg = SH_W'({wdata, addr[WR_ADDR_W-1:0]}) << (SH_W - WFRAME);
                        s_d.idx  = IW'(WFRAME - 1);
                    end
                end
            end
            ST_LEAD: if (tick) begin
                s_d.st   = ST_OPEN;
                s_d.sen  = 1'b0;
                s_d.sclk = 1'b0;
                s_d.sdo  = 1'b0;
                s_d.soe  = 1'b1;
                s_d.srw  = 1'b0;
            end
            ST_OPEN: if (tick) begin
                s_d.st   = ST_SEND;
                s_d.ph   = 1'b0;
                s_d.sdo  = s_q.sreg[SH_W-1];
                s_d.sreg = s_q.sreg << 1;
            end
            ST_SEND: if (tick) begin
                if (!s_q.ph) begin
                    // bit is settled: toggle the clock, rising on even bits
                    s_d.sclk = ~s_q.sclk;
                    s_d.ph   = 1'b1;
                end else if (s_q.idx != '0) begin
                    s_d.idx  = s_q.idx - 1'b1;
                    s_d.sdo  = s_q.sreg[SH_W-1];
                    s_d.sreg = s_q.sreg << 1;
                    s_d.ph   = 1'b0;
                end else if (s_q.rd) begin
                    s_d.st   = ST_TURN;
                    s_d.srw  = 1'b1;
                    s_d.sclk = 1'b0;
                end else begin
                    s_d.st   = ST_IDLE;
                    s_d.sen  = 1'b1;
                    s_d.sdo  = 1'b0;
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                end
            end
            ST_TURN: if (tick) begin
                s_d.st  = ST_REL;
                s_d.soe = 1'b0;
                s_d.idx = IW'(DATA_W - 1);
            end
            ST_REL: if (tick) begin
                s_d.st   = ST_RECV;
                s_d.sclk = 1'b1;
                s_d.ph   = 1'b1;
            end
            ST_RECV: if (tick) begin
                if (s_q.ph) begin
                    // clock has been high for a period: capture, then drop it
                    s_d.rsh  = {s_q.rsh[DATA_W-2:0], sdi};
                    s_d.sclk = 1'b0;
                    s_d.ph   = 1'b0;
                end else if (s_q.idx != '0) begin
                    s_d.idx  = s_q.idx - 1'b1;
                    s_d.sclk = 1'b1;
                    s_d.ph   = 1'b1;
                end else begin
                    s_d.st    = ST_IDLE;
                    s_d.sen   = 1'b1;
                    s_d.srw   = 1'b1;
                    s_d.soe   = 1'b1;
                    s_d.sdo   = 1'b0;
                    s_d.rdata = s_q.rsh;
                    s_d.busy  = 1'b0;
                    s_d.done  = 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.st    <= ST_IDLE;
            s_q.sen   <= 1'b1;
            s_q.soe   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy  = s_q.busy;
    assign done  = s_q.done;
    assign rdata = s_q.rdata;
    assign sen   = s_q.sen;
    assign sclk  = s_q.sclk;
    assign sdo   = s_q.sdo;
    assign soe   = s_q.soe;
    assign srw   = s_q.srw;
endmodule

// File: rtl/rfreg_3w_master.sv
module rfreg_3w_master #(
    parameter int CLK_DIV   = 4,
    parameter int WR_ADDR_W = 4,
    parameter int RD_ADDR_W = 5,
    parameter int DATA_W    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic                 req_rd,
    input  logic [RD_ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 busy,
    output logic                 done,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rf_en,
    output logic                 rf_clk,
    output logic                 rf_dat_o,
    output logic                 rf_dat_oe,
    input  logic                 rf_dat_i,
    output logic                 rf_rw
);
    logic tick;
    logic div_clr;

    rfreg_3w_tick #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (div_clr),
        .tick  (tick)
    );

    rfreg_3w_fsm #(
        .WR_ADDR_W (WR_ADDR_W),
        .RD_ADDR_W (RD_ADDR_W),
        .DATA_W    (DATA_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .start    (req),
        .start_rd (req_rd),
        .addr     (req_addr),
        .wdata    (req_wdata),
        .sdi      (rf_dat_i),
        .clr      (div_clr),
        .busy     (busy),
        .done     (done),
        .rdata    (rd_data),
        .sen      (rf_en),
        .sclk     (rf_clk),
        .sdo      (rf_dat_o),
        .soe      (rf_dat_oe),
        .srw      (rf_rw)
    );
endmodule

// File: rtl/rfreg_3w_checker.sv
module rfreg_3w_checker (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic rf_en,
    input logic rf_clk,
    input logic rf_dat_o,
    input logic rf_dat_oe,
    input logic rf_rw
);
    a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rf_en && !rf_clk && rf_dat_oe));

    a_r2_data_stable_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rf_clk) |-> $stable(rf_dat_o));

    a_r3_clock_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rf_clk) |-> !rf_en);

    a_r3_lead_period: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (rf_en && !rf_clk));

    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r4_done_at_close: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done && rf_en));

    a_r6_release_only_turned: assert property (@(posedge clk) disable iff (!rst_n)
        !rf_dat_oe |-> (rf_rw && !rf_en && busy));
endmodule

bind rfreg_3w_master rfreg_3w_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .rf_en     (rf_en),
    .rf_clk    (rf_clk),
    .rf_dat_o  (rf_dat_o),
    .rf_dat_oe (rf_dat_oe),
    .rf_rw     (rf_rw)
);

// File: tb/test_rfreg_3w_master.sv
module test_rfreg_3w_master;
    localparam int DIV = 3;
    localparam int WA  = 4;
    localparam int RA  = 5;
    localparam int DW  = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          req = 1'b0, req_rd = 1'b0;
    logic [RA-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          busy, done, rf_en, rf_clk, rf_dat_o, rf_dat_oe, rf_dat_i, rf_rw;
    logic [DW-1:0] rd_data;

    rfreg_3w_master #(.CLK_DIV(DIV)) i_rfreg_3w_master (
        .clk(clk), .rst_n(rst_n), .req(req), .req_rd(req_rd), .req_addr(req_addr),
        .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data),
        .rf_en(rf_en), .rf_clk(rf_clk), .rf_dat_o(rf_dat_o), .rf_dat_oe(rf_dat_oe),
        .rf_dat_i(rf_dat_i), .rf_rw(rf_rw)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    // stand-in radio: shifts out its word on falling serial clock edges
    logic [DW-1:0] slv_word = '0;
    int            slv_idx = DW - 1;
    logic          slv_pclk = 1'b0;
    always @(negedge clk) begin
        if (rf_dat_oe) slv_idx <= DW - 1;
        else if (slv_pclk && !rf_clk && slv_idx > 0) slv_idx <= slv_idx - 1;
        slv_pclk <= rf_clk;
    end
    assign rf_dat_i = slv_word[slv_idx];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_wr_word(input logic [RA-1:0] a, input logic [DW-1:0] d);
        return 32'({d, a[WA-1:0]});
    endfunction

    function automatic int exp_busy(input bit rd);
        return (rd ? 38 : 34) * DIV;
    endfunction

    function automatic int exp_enlow(input bit rd);
        return (rd ? 37 : 33) * DIV;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic run_frame(input bit rd, input logic [RA-1:0] a, input logic [DW-1:0] d,
                             input logic [DW-1:0] sw, input bit poke);
        int c = 0, busy_n = 0, enlow = 0, nbits = 0, ndone = 0, done_c = -1;
        int rw_rise = -1, oe_fall = -1, first_ret = -1;
        logic [31:0] bits = '0;
        logic first_dir = 1'b0, pclk, prw, poe;
        logic [DW-1:0] rdv = '0;
        logic c_en = 1'b0, c_clk = 1'b1, c_rw = 1'b0, c_oe = 1'b0;
        slv_word = sw;
        @(negedge clk);
        req = 1'b1; req_rd = rd; req_addr = a; req_wdata = d;
        @(negedge clk);
        req = 1'b0; req_wdata = DW'($urandom);
        pclk = rf_clk; prw = rf_rw; poe = rf_dat_oe;
        while (c < 60 * DIV) begin
            if (busy) busy_n++;
            if (!rf_en) enlow++;
            if (rf_clk !== pclk && !rf_en && rf_dat_oe && !rf_rw) begin
                bits = {bits[30:0], rf_dat_o};
                nbits++;
                if (nbits == 1) first_dir = rf_clk;
            end
            if (rf_rw && !prw && rw_rise < 0) rw_rise = c;
            if (!rf_dat_oe && poe) oe_fall = c;
            if (oe_fall >= 0 && first_ret < 0 && rf_clk && !pclk && !rf_dat_oe) first_ret = c;
            if (done) begin
                ndone++; done_c = c; rdv = rd_data;
                c_en = rf_en; c_clk = rf_clk; c_rw = rf_rw; c_oe = rf_dat_oe;
            end
            if (poke && c == 5 * DIV) begin
                req = 1'b1; req_rd = ~rd; req_addr = ~a; req_wdata = ~d;
            end else begin
                req = 1'b0;
            end
            if (done_c >= 0 && c >= done_c + 3) break;
            pclk = rf_clk; prw = rf_rw; poe = rf_dat_oe;
            @(negedge clk);
            c++;
        end
        req = 1'b0;
        chk("R4/R8 frame ended with done", 32'(ndone), 32'd1);
        chk(rd ? "R8 busy length" : "R4 busy length", 32'(busy_n), 32'(exp_busy(rd)));
        chk("R3 enable low span", 32'(enlow), 32'(exp_enlow(rd)));
        chk("R3 enable high at close", 32'(c_en), 32'd1);
        chk("R3 clock low at close", 32'(c_clk), 32'd0);
        chk("R1 idle after frame", 32'({rf_en, rf_clk, rf_dat_oe, busy}), 32'b1010);
        if (!rd) begin
            chk("R2 write bit count", 32'(nbits), 32'd16);
            chk("R2 write word", bits & 32'hFFFF, exp_wr_word(a, d));
            chk("R2 first edge rising", 32'(first_dir), 32'd1);
        end else begin
            chk("R5 address bit count", 32'(nbits), 32'd5);
            chk("R5 address bits", bits & 32'h1F, 32'(a));
            chk("R6 release after strobe", 32'(oe_fall - rw_rise), 32'(DIV));
            chk("R6 first return edge", 32'(first_ret - oe_fall), 32'(DIV));
            chk("R7 returned word", 32'(rdv), 32'(sw));
            chk("R8 strobe and enable at close", 32'({c_rw, c_oe}), 32'b11);
            chk("R8 strobe held after close", 32'(rf_rw), 32'd1);
        end
        if (poke) begin
            chk("R9 busy length with mid-frame request", 32'(busy_n), 32'(exp_busy(rd)));
            chk("R9 bits unchanged by mid-frame request", 32'(nbits), rd ? 32'd5 : 32'd16);
        end
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (4) @(negedge clk);
        chk("R1 reset lines", 32'({rf_en, rf_clk, rf_dat_oe, rf_rw, busy, done}), 32'b101000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle after reset", 32'({rf_en, rf_clk, rf_dat_oe, rf_rw, busy, done}), 32'b101000);

        // directed corners
        run_frame(1'b0, 5'h0F, 12'hFFF, 12'h000, 1'b0);
        run_frame(1'b0, 5'h10, 12'h000, 12'h000, 1'b0);
        run_frame(1'b1, 5'h1F, 12'h000, 12'hA5A, 1'b0);
        run_frame(1'b1, 5'h00, 12'h000, 12'hFFF, 1'b0);
        run_frame(1'b0, 5'h07, 12'h8C3, 12'h000, 1'b1);
        run_frame(1'b1, 5'h08, 12'h000, 12'h588, 1'b1);
        run_frame(1'b0, 5'h04, 12'h1F0, 12'h000, 1'b0);

        // constrained random mix
        for (int i = 0; i < 40; i++) begin
            run_frame(1'($urandom), RA'($urandom), DW'($urandom), DW'($urandom),
                      ($urandom % 4) == 0);
            repeat ($urandom % 3) @(negedge clk);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule